// File: doc/BRIEF.md
# Posted Write Buffer for CPU-to-Memory Writes

This block sits between a CPU request port and a memory write port. It stores one CPU write transaction of up to four words, together with a single base address, and finishes the write on the CPU side without wait states. While the CPU goes on, the block drains the stored words to memory one at a time, starting with the cycle after the first word arrives. Memory timing stays outside the block: the memory port is a valid/ready pair.

Only one transaction can be held, because there is only one address register. A later CPU transaction that targets system memory sees ready low until the buffer has emptied, whether it is a read or a write. A transaction that targets the internal bus sees ready high and completes while the drain goes on. The block only gates ready for reads. The read path itself lies outside it.

A write transaction is presented as consecutive data beats with `cpu_valid` high. The first beat carries the word address and the size. The beats after it carry only data, and the block takes them without stalling.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset `wbuf_empty` is 1 and `mem_wvalid` is 0. With no transaction being filled, `cpu_ready` is 1.
- R2: When the buffer is empty, a memory-targeted write (`cpu_valid`=1, `cpu_we`=1, `cpu_to_mem`=1) is taken in the same cycle with `cpu_ready`=1. `cpu_size` selects the length: 2'b00 is 1 word, 2'b01 is 2 words, and 2'b10 or 2'b11 is 4 words. The follow-on beats come on later `cpu_valid` cycles, and each one also sees `cpu_ready`=1.
- R3: `mem_wvalid` is 1 in the cycle after the first word is taken, before the transaction has finished filling.
- R4: Words go to memory in the order they arrived. Word k goes to word address base+k, wrapping modulo 2^AW.
- R5: While `mem_wvalid` is 1 and `mem_wready` is 0, `mem_waddr` and `mem_wdata` hold their values into the next cycle.
- R6: While the buffer is not empty and no transaction is filling, a memory-targeted read or write sees `cpu_ready`=0.
- R7: A transaction with `cpu_to_mem`=0 (internal bus) always sees `cpu_ready`=1, even while the buffer drains.
- R8: `wbuf_empty` rises in the cycle after memory accepts the last word. While it is 1, `mem_wvalid` is 0.
- R9: A memory write to the address right after the stored transaction still stalls while the buffer is occupied. It is taken only once the buffer is empty.
- R10: The buffer never holds more than DEPTH words. Exactly as many words as the size selected are written to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU transaction or data beat present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_to_mem | input | 1 | 1 = system memory target, 0 = internal bus target |
| cpu_size | input | 2 | Write length code (see R2) |
| cpu_addr | input | AW | Word address, used on the first beat |
| cpu_wdata | input | DW | Write data beat |
| cpu_ready | output | 1 | Transaction may complete this cycle |
| mem_wvalid | output | 1 | A buffered word is offered to memory |
| mem_wready | input | 1 | Memory accepts the offered word |
| mem_waddr | output | AW | Word address of the offered word |
| mem_wdata | output | DW | Offered data word |
| wbuf_empty | output | 1 | Buffer holds no undrained word |

## Verification
The assertions check on every cycle that memory-bound requests stall while words are outstanding and that internal-bus requests never stall. They also check that a stalled memory word stays stable, that successive drained addresses step by one, that the buffer empties one cycle after the last accept, and that the word counters never pass the depth. Only the bench scenarios can show that the drained data matches what the CPU wrote for each size code, including address wrap, and that an adjacent-address write waits and then lands behind the first transaction. The bench also shows that exactly the selected number of words reaches memory under different back-pressure patterns.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Write length codes carried on the first beat
  typedef enum logic [1:0] {
    SZ_ONE  = 2'b00,
    SZ_TWO  = 2'b01,
    SZ_FOUR = 2'b10,
    SZ_ALT4 = 2'b11
  } wsize_e;

  // Number of beats for a size code (R2)
  function automatic int unsigned beats_of(input logic [1:0] code);
    case (wsize_e'(code))
      SZ_ONE:  beats_of = 1;
      SZ_TWO:  beats_of = 2;
      default: beats_of = 4;
    endcase
  endfunction
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic             cpu_to_mem,
  input  logic [1:0]       cpu_size,
  input  logic             mem_wready,
  output logic             cpu_ready,
  output logic             take_first,
  output logic             take_word,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             mem_wvalid,
  output logic             drain_fire,
  output logic             wbuf_empty
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             filling_q, busy_q;
  logic [CNT_W-1:0] len_q, wr_cnt_q, rd_cnt_q;
  logic [CNT_W-1:0] first_len;
  logic             take_next, last_drain;

  assign first_len  = CNT_W'(beats_of(cpu_size));
  assign take_first = cpu_valid & cpu_we & cpu_to_mem & ~filling_q & ~busy_q;
  assign take_next  = cpu_valid & filling_q;
  assign take_word  = take_first | take_next;
  assign wr_idx     = take_first ? '0 : wr_cnt_q[IDX_W-1:0];
  assign rd_idx     = rd_cnt_q[IDX_W-1:0];

  // R6/R7/R9: only memory-bound requests wait for the drain
  assign cpu_ready  = filling_q | ~cpu_to_mem | ~busy_q;
  assign mem_wvalid = busy_q & (rd_cnt_q < wr_cnt_q);
  assign drain_fire = mem_wvalid & mem_wready;
  assign last_drain = drain_fire & ((rd_cnt_q + ONE) == len_q);
  assign wbuf_empty = ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin           // R1
      filling_q <= 1'b0;
      busy_q    <= 1'b0;
      len_q     <= '0;
      wr_cnt_q  <= '0;
      rd_cnt_q  <= '0;
    end else if (take_first) begin
      len_q     <= first_len;
      wr_cnt_q  <= ONE;
      rd_cnt_q  <= '0;
      busy_q    <= 1'b1;
      filling_q <= (first_len > ONE);
    end else begin
      if (take_next) begin
        wr_cnt_q <= wr_cnt_q + ONE;
        if ((wr_cnt_q + ONE) == len_q) filling_q <= 1'b0;
      end
      if (drain_fire) begin
        rd_cnt_q <= rd_cnt_q + ONE;
        if (last_drain) busy_q <= 1'b0;
      end
    end
  end

  p_stall_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_to_mem && !filling_q && !wbuf_empty) |-> !cpu_ready);
  p_ibus_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_to_mem) |-> cpu_ready);
  p_drain_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_first |=> mem_wvalid);
  p_empty_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_drain |=> wbuf_empty);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_empty |-> !mem_wvalid);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_q <= CNT_W'(DEPTH)) && (rd_cnt_q <= wr_cnt_q) && (wr_cnt_q <= len_q));
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_first,
  input  logic             take_word,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [AW-1:0]    mem_waddr,
  output logic [DW-1:0]    mem_wdata
);
  logic [AW-1:0] base_q;
  logic [DW-1:0] slot_q [DEPTH];

  // R4: word k of the transaction lands at base + k
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic [IDX_W-1:0] k);
    slot_addr = base + AW'(k);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (take_first) base_q <= cpu_addr;
  end

  always_ff @(posedge clk) begin
    if (take_word) slot_q[wr_idx] <= cpu_wdata;
  end

  assign mem_waddr = slot_addr(base_q, rd_idx);
  assign mem_wdata = slot_q[rd_idx];
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic          cpu_to_mem,
  input  logic [1:0]    cpu_size,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          mem_wvalid,
  input  logic          mem_wready,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          wbuf_empty
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             take_first, take_word, drain_fire;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  pwb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_to_mem(cpu_to_mem),
    .cpu_size(cpu_size), .mem_wready(mem_wready),
    .cpu_ready(cpu_ready), .take_first(take_first), .take_word(take_word),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .mem_wvalid(mem_wvalid),
    .drain_fire(drain_fire), .wbuf_empty(wbuf_empty)
  );

  pwb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .take_first(take_first), .take_word(take_word),
    .wr_idx(wr_idx), .rd_idx(rd_idx),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drain_fire |=> (!mem_wvalid || (mem_waddr == $past(mem_waddr) + AW'(1))));
endmodule

// File: tb/tb_posted_wr_buf.sv
`timescale 1ns/1ps
module tb_posted_wr_buf;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct packed {
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] seed;
    logic [3:0]  mask;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 32'h0000_0100, 32'hA000_0000, 4'b0101},
    '{2'd1, 32'h0000_0200, 32'hB100_0000, 4'b1111},
    '{2'd2, 32'h0000_0300, 32'hC200_0000, 4'b1001},
    '{2'd2, 32'hFFFF_FFFE, 32'hD300_0000, 4'b1111},
    '{2'd3, 32'h0000_0040, 32'hE400_0000, 4'b0011},
    '{2'd1, 32'h0000_0007, 32'hF500_0000, 4'b0110}
  };

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cpu_valid = 0, cpu_we = 0, cpu_to_mem = 0;
  logic [1:0]    cpu_size = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0;
  logic          cpu_ready, mem_wvalid, wbuf_empty;
  logic          mem_wready = 0;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  int   tests = 0, fails = 0, cyc = 0, cap_n = 0;
  logic [3:0]    wr_mask = 4'b0000;
  logic [AW-1:0] cap_addr [64];
  logic [DW-1:0] cap_data [64];
  logic          hold_pend = 0;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  bit            done = 0;

  posted_wr_buf #(.AW(AW), .DW(DW), .DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_to_mem(cpu_to_mem), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .mem_wvalid(mem_wvalid),
    .mem_wready(mem_wready), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wbuf_empty(wbuf_empty)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory side: back-pressure pattern and write capture
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_wready <= wr_mask[cyc % 4];
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(mem_wvalid && mem_waddr == hold_addr && mem_wdata == hold_data,
            "R5", "stalled word held", longint'(mem_waddr), longint'(hold_addr));
      if (mem_wvalid && mem_wready && cap_n < 64) begin
        cap_addr[cap_n] = mem_waddr;
        cap_data[cap_n] = mem_wdata;
        cap_n++;
      end
      hold_pend = mem_wvalid && !mem_wready;
      hold_addr = mem_waddr;
      hold_data = mem_wdata;
    end
  end

  task automatic wait_empty();
    for (int i = 0; i < 60 && !wbuf_empty; i++) @(negedge clk);
    chk(wbuf_empty, "R8", "buffer drained", longint'(wbuf_empty), 1);
  endtask

  task automatic drive_wr(input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [DW-1:0] d);
    cpu_valid = 1; cpu_we = 1; cpu_to_mem = 1; cpu_size = sz;
    cpu_addr = a; cpu_wdata = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk(wbuf_empty == 1, "R1", "empty in reset", longint'(wbuf_empty), 1);
    chk(mem_wvalid == 0, "R1", "wvalid in reset", longint'(mem_wvalid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready == 1, "R1", "ready idle", longint'(cpu_ready), 1);
    chk(wbuf_empty == 1 && mem_wvalid == 0, "R1", "idle after reset",
        longint'({wbuf_empty, mem_wvalid}), 2);

    // Vector table: sizes, bases and back-pressure patterns
    foreach (VEC[v]) begin
      wr_mask = VEC[v].mask;
      n = (VEC[v].size == 2'd0) ? 1 : (VEC[v].size == 2'd1) ? 2 : 4;
      @(negedge clk);
      cap_n = 0;
      drive_wr(VEC[v].addr, VEC[v].size, VEC[v].seed);
      #1 chk(cpu_ready == 1, "R2", "first beat ready", longint'(cpu_ready), 1);
      for (int k = 1; k <= n; k++) begin
        @(negedge clk);
        if (k == 1)
          chk(mem_wvalid == 1, "R3", "drain starts", longint'(mem_wvalid), 1);
        if (k < n) begin
          cpu_wdata = VEC[v].seed + DW'(k);
          cpu_addr  = 32'h0;
          #1 chk(cpu_ready == 1, "R2", "follow beat ready", longint'(cpu_ready), 1);
        end else cpu_valid = 0;
      end
      if (!wbuf_empty) begin
        cpu_valid = 1; cpu_we = 0; cpu_to_mem = 1;
        #1 chk(cpu_ready == 0, "R6", "mem read stalls", longint'(cpu_ready), 0);
        cpu_to_mem = 0;
        #1 chk(cpu_ready == 1, "R7", "ibus not stalled", longint'(cpu_ready), 1);
        cpu_valid = 0;
      end
      wait_empty();
      chk(cap_n == n, "R10", "word count", longint'(cap_n), longint'(n));
      for (int k = 0; k < n; k++) begin
        chk(cap_addr[k] == VEC[v].addr + AW'(k), "R4", "drain address",
            longint'(cap_addr[k]), longint'(VEC[v].addr + AW'(k)));
        chk(cap_data[k] == VEC[v].seed + DW'(k), "R4", "drain data",
            longint'(cap_data[k]), longint'(VEC[v].seed + DW'(k)));
      end
    end

    // R8: exact empty timing with memory always ready
    wr_mask = 4'b1111;
    @(negedge clk); @(negedge clk);
    cap_n = 0;
    drive_wr(32'h500, 2'd0, 32'h5555_0001);
    @(negedge clk);
    cpu_valid = 0;
    chk(mem_wvalid == 1, "R3", "valid next cycle", longint'(mem_wvalid), 1);
    chk(wbuf_empty == 0, "R8", "not empty before accept", longint'(wbuf_empty), 0);
    @(negedge clk);
    chk(wbuf_empty == 1, "R8", "empty after last accept", longint'(wbuf_empty), 1);
    chk(mem_wvalid == 0, "R8", "no valid when empty", longint'(mem_wvalid), 0);
    chk(cap_n == 1, "R8", "one word written", longint'(cap_n), 1);

    // R9: adjacent-address write waits behind the stored one
    wr_mask = 4'b0000;
    @(negedge clk); @(negedge clk);
    cap_n = 0;
    drive_wr(32'h600, 2'd0, 32'h6666_0000);
    @(negedge clk);
    cpu_valid = 0;
    @(negedge clk);
    drive_wr(32'h601, 2'd0, 32'h6666_0001);
    for (int i = 0; i < 3; i++) begin
      #1 chk(cpu_ready == 0, "R9", "adjacent write stalls", longint'(cpu_ready), 0);
      @(negedge clk);
    end
    chk(mem_waddr == 32'h600 && cap_n == 0, "R9", "first word still held",
        longint'(mem_waddr), 32'h600);
    wr_mask = 4'b1111;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
    end
    chk(cpu_ready == 1 && wbuf_empty == 1, "R9", "taken once empty",
        longint'({cpu_ready, wbuf_empty}), 3);
    @(negedge clk);
    cpu_valid = 0;
    wait_empty();
    chk(cap_n == 2 && cap_addr[0] == 32'h600 && cap_addr[1] == 32'h601,
        "R9", "order of the two writes", longint'(cap_addr[1]), 32'h601);
    chk(cap_data[1] == 32'h6666_0001, "R9", "second data",
        longint'(cap_data[1]), 32'h6666_0001);

    // R10: full buffer with memory blocked
    wr_mask = 4'b0000;
    @(negedge clk); @(negedge clk);
    cap_n = 0;
    drive_wr(32'h800, 2'd2, 32'h8000_0000);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      cpu_wdata = 32'h8000_0000 + DW'(k);
    end
    @(negedge clk);
    cpu_valid = 0;
    repeat (3) @(negedge clk);
    chk(cap_n == 0 && wbuf_empty == 0, "R10", "held while blocked",
        longint'(cap_n), 0);
    drive_wr(32'h900, 2'd0, 32'h9);
    #1 chk(cpu_ready == 0, "R10", "full buffer refuses write", longint'(cpu_ready), 0);
    cpu_to_mem = 0;
    #1 chk(cpu_ready == 1, "R7", "ibus passes full buffer", longint'(cpu_ready), 1);
    cpu_valid = 0;
    wr_mask = 4'b1111;
    @(negedge clk);
    wait_empty();
    chk(cap_n == 4, "R10", "four words drained", longint'(cap_n), 4);
    chk(cap_data[3] == 32'h8000_0003, "R4", "last word", longint'(cap_data[3]),
        32'h8000_0003);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule